// File: doc/BRIEF.md
# Paged Dot-Matrix Refresh Controller

This block keeps a monochrome dot-matrix panel refreshed from a paged frame store. The store holds a number of pages, and each page holds one full bit plane of the panel. A CPU reaches the store through two byte-wide windows. Each window maps onto a page chosen by its own page register. The refresh side fetches one byte of the displayed page at a paced rate and shifts it out as a serial pixel stream with row and frame markers. It counts the row being refreshed and can raise an interrupt once a programmed row has been fully sent.

Software updates the displayed page by writing the visible-page register. The new page is taken up only at the next frame boundary, so a frame never tears. Writing the scanline register arms a one-shot compare, which lets software flip pages at a chosen point in the frame. The CPU port never waits: window accesses use a port of the frame store of their own, separate from the refresh read port.

Top module: `dmd_refresh_ctrl`

## Requirements
- R1: When `cpu_addr` MSB is 0, the access goes to a window. The next bit selects window B (1) or window A (0), and the low bits give the byte offset. Register 0 sets the page for window A and register 1 sets the page for window B. A byte written through one window reads back through the other when both point at the same page. Read data appears on `cpu_rdata` in the cycle after the access.
- R2: After reset, every register (indices 0 to 4) reads 0 and `irq` is low.
- R3: A frame is sent row by row from row 0. Within a row, bytes go out in rising column order (page byte offset = row*COLS/8 + column), and each byte goes out least significant bit first.
- R4: `px_row_start` is high with the first bit of every row. `px_frame_start` is high with the first bit of row 0 only.
- R5: The pixel stream is valid/ready. While `px_valid` is high and `px_ready` is low, the data bit and markers hold. Holding ready low stalls the scan, and no pixel is dropped or repeated.
- R6: Byte fetches are at least FETCH_DIV cycles apart. With `px_ready` held high, the first bits of consecutive bytes are exactly FETCH_DIV cycles apart.
- R7: A write to register 2 (visible page) is held pending. The frame in progress finishes from the old page, and the next frame comes from the new one. Reading register 2 returns the page being displayed.
- R8: Reading register 3 returns the row of the byte currently being shifted out (0 to ROWS-1).
- R9: Writing register 3 stores a compare row and arms the compare. In the cycle after the last bit of that row is accepted, the pending flag (register 4 bit 1) sets and the compare disarms, so it fires only once per write.
- R10: `irq` equals pending AND enable (register 4 bit 0). Writing register 4 sets the enable from bit 0 and clears pending when bit 1 is 1. Pending stays set while masked, and `irq` rises when the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_cs | input | 1 | CPU access strobe, one cycle per access |
| cpu_we | input | 1 | Write (1) or read (0) |
| cpu_addr | input | WIN_AW+2 | MSB=1: register index in bits [2:0]; else window select and offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after a read |
| px_valid | output | 1 | Pixel bit available |
| px_ready | input | 1 | Panel accepts the pixel bit |
| px_data | output | 1 | Pixel bit |
| px_row_start | output | 1 | First bit of a row |
| px_frame_start | output | 1 | First bit of a frame |
| irq | output | 1 | Row-compare interrupt request |

## Verification
The bench builds the block with a 16-column, 4-row panel, 4 pages and a fetch spacing of 16 cycles. A frame then lasts about 128 cycles. This short frame lets the run cover many frame wraps, deferred page swaps, every row as a compare target, and long stretches of random back-pressure. It does this while still using more than one byte per row and more than one page, so the column ordering and page addressing are exercised.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  typedef enum logic [2:0] {
    REG_WIN_A    = 3'd0,
    REG_WIN_B    = 3'd1,
    REG_VISIBLE  = 3'd2,
    REG_SCANLINE = 3'd3,
    REG_IRQ      = 3'd4
  } dmd_reg_e;

  localparam int IRQ_EN_BIT   = 0;
  localparam int IRQ_PEND_BIT = 1;
  localparam int LANES        = 4;
endpackage

// File: rtl/dmd_frame_ram.sv
module dmd_frame_ram #(
  parameter int WORDS = 2048,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [3:0]    a_be,
  input  logic [31:0]   a_wdata,
  output logic [31:0]   a_rdata,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output logic [31:0]   b_rdata
);
  logic [31:0] mem [WORDS];

  // CPU port: byte-lane writes, registered reads
  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) begin
        for (int l = 0; l < 4; l++) begin
          if (a_be[l]) mem[a_addr][l*8 +: 8] <= a_wdata[l*8 +: 8];
        end
      end else begin
        a_rdata <= mem[a_addr];
      end
    end
  end

  // refresh port: read only
  always_ff @(posedge clk) begin
    if (b_en) b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/dmd_regs.sv
module dmd_regs
  import dmd_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int ROW_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_idx,
  input  logic [7:0]        reg_wdata,
  input  logic [ROW_W-1:0]  cur_row,
  input  logic              row_done,
  input  logic              frame_done,
  output logic [PAGE_W-1:0] win_a_page,
  output logic [PAGE_W-1:0] win_b_page,
  output logic [PAGE_W-1:0] vis_page,
  output logic              irq,
  output logic [7:0]        reg_rdata
);
  logic [PAGE_W-1:0] vis_next;
  logic [ROW_W-1:0]  cmp_row;
  logic              armed;
  logic              irq_en;
  logic              irq_pend;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_a_page <= '0;
      win_b_page <= '0;
      vis_next   <= '0;
      vis_page   <= '0;
      cmp_row    <= '0;
      armed      <= 1'b0;
      irq_en     <= 1'b0;
      irq_pend   <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_idx)
          REG_WIN_A:    win_a_page <= reg_wdata[PAGE_W-1:0];
          REG_WIN_B:    win_b_page <= reg_wdata[PAGE_W-1:0];
          REG_VISIBLE:  vis_next   <= reg_wdata[PAGE_W-1:0];
          REG_SCANLINE: begin
            cmp_row <= reg_wdata[ROW_W-1:0];
            armed   <= 1'b1;
          end
          REG_IRQ: begin
            irq_en <= reg_wdata[IRQ_EN_BIT];
            if (reg_wdata[IRQ_PEND_BIT]) irq_pend <= 1'b0;
          end
          default: ;
        endcase
      end
      // retrace: pending page becomes the displayed page
      if (frame_done) vis_page <= vis_next;
      // row compare: one shot, set wins over a same-cycle clear
      if (row_done && armed && (cur_row == cmp_row)) begin
        irq_pend <= 1'b1;
        armed    <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_idx)
        REG_WIN_A:    reg_rdata <= 8'(win_a_page);
        REG_WIN_B:    reg_rdata <= 8'(win_b_page);
        REG_VISIBLE:  reg_rdata <= 8'(vis_page);
        REG_SCANLINE: reg_rdata <= 8'(cur_row);
        REG_IRQ:      reg_rdata <= {6'd0, irq_pend, irq_en};
        default:      reg_rdata <= '0;
      endcase
    end
  end

  assign irq = irq_pend & irq_en;
endmodule

// File: rtl/dmd_scan_seq.sv
module dmd_scan_seq #(
  parameter int PAGE_W    = 4,
  parameter int ROW_W     = 5,
  parameter int COL_W     = 4,
  parameter int FETCH_DIV = 32,
  parameter int BA_W      = PAGE_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] vis_page,
  output logic              rd_en,
  output logic [BA_W-1:0]   rd_addr,
  input  logic [31:0]       rd_word,
  output logic              px_valid,
  input  logic              px_ready,
  output logic              px_data,
  output logic              px_row_start,
  output logic              px_frame_start,
  output logic [ROW_W-1:0]  cur_row,
  output logic              row_done,
  output logic              frame_done
);
  localparam int GAP_W = (FETCH_DIV > 2) ? $clog2(FETCH_DIV) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(FETCH_DIV - 1);
  localparam logic [COL_W-1:0] COL_LAST = '1;
  localparam logic [ROW_W-1:0] ROW_LAST = '1;

  logic [3:0]       bit_cnt;
  logic [7:0]       shreg;
  logic             f_wait;
  logic [1:0]       lane_q;
  logic [GAP_W-1:0] gap;
  logic [ROW_W-1:0] nxt_row;
  logic [COL_W-1:0] nxt_col;
  logic [COL_W-1:0] cur_col;
  logic             accept;

  assign rd_en   = (bit_cnt == 4'd0) && !f_wait && (gap == GAP_LAST);
  assign rd_addr = {vis_page, nxt_row, nxt_col};

  assign px_valid       = (bit_cnt != 4'd0);
  assign px_data        = shreg[0];
  assign px_row_start   = (bit_cnt == 4'd8) && (cur_col == '0);
  assign px_frame_start = px_row_start && (cur_row == '0);

  assign accept     = px_valid && px_ready;
  assign row_done   = accept && (bit_cnt == 4'd1) && (cur_col == COL_LAST);
  assign frame_done = row_done && (cur_row == ROW_LAST);

  // fetch pacing and position counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap     <= '0;
      f_wait  <= 1'b0;
      lane_q  <= '0;
      nxt_row <= '0;
      nxt_col <= '0;
      cur_row <= '0;
      cur_col <= '0;
    end else begin
      f_wait <= rd_en;
      if (rd_en) begin
        gap     <= '0;
        lane_q  <= rd_addr[1:0];
        cur_row <= nxt_row;
        cur_col <= nxt_col;
        nxt_col <= nxt_col + 1'b1;
        if (nxt_col == COL_LAST) nxt_row <= nxt_row + 1'b1;
      end else if (gap != GAP_LAST) begin
        gap <= gap + 1'b1;
      end
    end
  end

  // serializer: LSB first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (f_wait) begin
      shreg   <= rd_word[{lane_q, 3'b000} +: 8];
      bit_cnt <= 4'd8;
    end else if (accept) begin
      shreg   <= {1'b0, shreg[7:1]};
      bit_cnt <= bit_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dmd_refresh_ctrl.sv
module dmd_refresh_ctrl #(
  parameter int COLS      = 128,
  parameter int ROWS      = 32,
  parameter int PAGES     = 16,
  parameter int FETCH_DIV = 32,
  parameter int WIN_AW    = $clog2(ROWS) + $clog2(COLS / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_cs,
  input  logic              cpu_we,
  input  logic [WIN_AW+1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              px_valid,
  input  logic              px_ready,
  output logic              px_data,
  output logic              px_row_start,
  output logic              px_frame_start,
  output logic              irq
);
  localparam int COL_W  = $clog2(COLS / 8);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int PAGE_W = $clog2(PAGES);
  localparam int BA_W   = PAGE_W + WIN_AW;
  localparam int WA_W   = BA_W - 2;
  localparam int WORDS  = PAGES * (COLS / 8) * ROWS / 4;

  logic              is_reg;
  logic              sel_b;
  logic [PAGE_W-1:0] win_a_page, win_b_page, vis_page;
  logic [BA_W-1:0]   cpu_ba;
  logic [31:0]       ram_a_rdata, ram_b_rdata;
  logic              seq_fetch;
  logic [BA_W-1:0]   seq_addr;
  logic [ROW_W-1:0]  cur_row;
  logic              row_done, frame_done;
  logic              reg_wr, reg_rd;
  logic [7:0]        reg_rdata;
  logic              rd_reg_q;
  logic [1:0]        rd_lane_q;

  assign is_reg = cpu_addr[WIN_AW+1];
  assign sel_b  = cpu_addr[WIN_AW];
  assign cpu_ba = {(sel_b ? win_b_page : win_a_page), cpu_addr[WIN_AW-1:0]};
  assign reg_wr = cpu_cs && is_reg && cpu_we;
  assign reg_rd = cpu_cs && is_reg && !cpu_we;

  dmd_frame_ram #(.WORDS(WORDS), .AW(WA_W)) i_ram (
    .clk     (clk),
    .a_en    (cpu_cs && !is_reg),
    .a_we    (cpu_we),
    .a_addr  (cpu_ba[BA_W-1:2]),
    .a_be    (4'b0001 << cpu_ba[1:0]),
    .a_wdata ({4{cpu_wdata}}),
    .a_rdata (ram_a_rdata),
    .b_en    (seq_fetch),
    .b_addr  (seq_addr[BA_W-1:2]),
    .b_rdata (ram_b_rdata)
  );

  dmd_regs #(.PAGE_W(PAGE_W), .ROW_W(ROW_W)) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_idx    (cpu_addr[2:0]),
    .reg_wdata  (cpu_wdata),
    .cur_row    (cur_row),
    .row_done   (row_done),
    .frame_done (frame_done),
    .win_a_page (win_a_page),
    .win_b_page (win_b_page),
    .vis_page   (vis_page),
    .irq        (irq),
    .reg_rdata  (reg_rdata)
  );

  dmd_scan_seq #(
    .PAGE_W(PAGE_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .FETCH_DIV(FETCH_DIV), .BA_W(BA_W)
  ) i_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .vis_page       (vis_page),
    .rd_en          (seq_fetch),
    .rd_addr        (seq_addr),
    .rd_word        (ram_b_rdata),
    .px_valid       (px_valid),
    .px_ready       (px_ready),
    .px_data        (px_data),
    .px_row_start   (px_row_start),
    .px_frame_start (px_frame_start),
    .cur_row        (cur_row),
    .row_done       (row_done),
    .frame_done     (frame_done)
  );

  // read source and lane follow the access by one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_reg_q  <= 1'b0;
      rd_lane_q <= '0;
    end else if (cpu_cs && !cpu_we) begin
      rd_reg_q  <= is_reg;
      rd_lane_q <= cpu_ba[1:0];
    end
  end

  assign cpu_rdata = rd_reg_q ? reg_rdata : ram_a_rdata[{rd_lane_q, 3'b000} +: 8];
endmodule

// File: rtl/dmd_refresh_ctrl_chk.sv
module dmd_refresh_ctrl_chk #(
  parameter int FETCH_DIV = 32,
  parameter int PAGE_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              px_valid,
  input logic              px_ready,
  input logic              px_data,
  input logic              px_row_start,
  input logic              px_frame_start,
  input logic              irq,
  input logic              fetch,
  input logic [PAGE_W-1:0] vis_page,
  input logic              frame_done,
  input logic              row_done,
  input logic              reg_wr
);
  logic [31:0] since_fetch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   since_fetch <= '0;
    else if (fetch)               since_fetch <= '0;
    else if (since_fetch != '1)   since_fetch <= since_fetch + 1'b1;
  end

  assert_px_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && !px_ready |=> px_valid && $stable(px_data) && $stable(px_row_start)
                              && $stable(px_frame_start));

  assert_frame_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    px_frame_start |-> px_row_start && px_valid);

  assert_fetch_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> since_fetch >= 32'(FETCH_DIV - 1));

  assert_vis_retrace_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vis_page) |-> $past(frame_done));

  // R9 / R10: irq rises only from a row completion or a control write
  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(row_done) || $past(reg_wr));
endmodule

bind dmd_refresh_ctrl dmd_refresh_ctrl_chk #(.FETCH_DIV(FETCH_DIV), .PAGE_W(PAGE_W)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .px_valid       (px_valid),
  .px_ready       (px_ready),
  .px_data        (px_data),
  .px_row_start   (px_row_start),
  .px_frame_start (px_frame_start),
  .irq            (irq),
  .fetch          (seq_fetch),
  .vis_page       (vis_page),
  .frame_done     (frame_done),
  .row_done       (row_done),
  .reg_wr         (reg_wr)
);

// File: tb/test_dmd_refresh_ctrl.sv
module test_dmd_refresh_ctrl;
  localparam int COLS = 16, ROWS = 4, PAGES = 4, FETCH_DIV = 16;
  localparam int BPR = COLS / 8, PB = BPR * ROWS, AW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_cs = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic px_valid, px_ready, px_data, px_row_start, px_frame_start, irq;

  always #2 clk = ~clk;

  dmd_refresh_ctrl #(.COLS(COLS), .ROWS(ROWS), .PAGES(PAGES), .FETCH_DIV(FETCH_DIV)) i_dmd_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_cs(cpu_cs), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .px_valid(px_valid), .px_ready(px_ready),
    .px_data(px_data), .px_row_start(px_row_start), .px_frame_start(px_frame_start), .irq(irq));

  typedef struct {bit d; bit rs; bit fs; int row; int bnum; bit last;} beat_t;
  beat_t exp_q[$];
  logic [7:0] model [PAGES*PB];
  int checks = 0, errors = 0, cyc = 0, last_start = -1, irq_row = 0;
  bit in_sync = 0, bp_mode = 0, pace_on = 0, irq_watch = 0, irq_due = 0, done = 0;

  always @(posedge clk) cyc++;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_frame(int page);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < BPR; c++)
        for (int b = 0; b < 8; b++) begin
          beat_t it;
          it.d = model[page*PB + r*BPR + c][b];
          it.rs = (c == 0 && b == 0);
          it.fs = it.rs && r == 0;
          it.row = r; it.bnum = b;
          it.last = (c == BPR-1 && b == 7);
          exp_q.push_back(it);
        end
  endtask

  task automatic cpu_write(logic [AW-1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    cpu_cs = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #1;
    cpu_cs = 0; cpu_we = 0;
  endtask

  task automatic cpu_read(logic [AW-1:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    cpu_cs = 1; cpu_we = 0; cpu_addr = a;
    @(posedge clk); #1;
    cpu_cs = 0;
    @(negedge clk);
    d = cpu_rdata;
  endtask

  function automatic logic [AW-1:0] reg_a(int idx); return AW'(16 + idx); endfunction
  function automatic logic [AW-1:0] win_a(int off); return AW'(off); endfunction
  function automatic logic [AW-1:0] win_b(int off); return AW'(8 + off); endfunction

  task automatic wait_empty();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic wait_sync();
    while (!in_sync) @(negedge clk);
  endtask

  // ready driver
  initial begin
    px_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      px_ready = bp_mode ? 1'($urandom_range(0, 1)) : 1'b1;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_due) begin
        chk(irq == 1'b1, "R9", "irq one cycle after compare row end", int'(irq), 1);
        irq_due = 0;
      end
      if (px_valid && px_ready && exp_q.size() > 0) begin
        if (!in_sync && px_frame_start) begin
          in_sync = 1;
          last_start = -1;
        end
        if (in_sync) begin
          beat_t it;
          it = exp_q.pop_front();
          chk(px_data == it.d, "R3", "pixel bit", int'(px_data), int'(it.d));
          chk({px_row_start, px_frame_start} == {it.rs, it.fs}, "R4", "row/frame markers",
              int'({px_row_start, px_frame_start}), int'({it.rs, it.fs}));
          if (it.bnum == 0) begin
            if (pace_on && last_start >= 0)
              chk(cyc - last_start == FETCH_DIV, "R6", "byte spacing", cyc - last_start, FETCH_DIV);
            last_start = cyc;
          end
          if (irq_watch && it.last && it.row == irq_row) begin
            chk(irq == 1'b0, "R9", "irq before compare row end", int'(irq), 0);
            irq_due = 1;
          end
          if (exp_q.size() == 0) in_sync = 0;
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2 reset values
    @(negedge clk);
    chk(irq == 1'b0, "R2", "irq after reset", int'(irq), 0);
    for (int i = 0; i < 5; i++) begin
      cpu_read(reg_a(i), d);
      chk(d == 8'd0, "R2", "register reset value", int'(d), 0);
    end

    // fill all pages through window A
    for (int p = 0; p < PAGES; p++) begin
      cpu_write(reg_a(0), 8'(p));
      for (int o = 0; o < PB; o++) begin
        model[p*PB + o] = 8'((p*PB + o) * 29 + 7) ^ 8'((p*PB + o) >> 2);
        cpu_write(win_a(o), model[p*PB + o]);
      end
    end

    // R1 windows
    cpu_write(reg_a(1), 8'd2);
    cpu_read(win_b(3), d);
    chk(d == model[2*PB + 3], "R1", "window B read page 2", int'(d), int'(model[2*PB + 3]));
    cpu_read(reg_a(1), d);
    chk(d == 8'd2, "R1", "window B page register", int'(d), 2);
    cpu_write(reg_a(1), 8'd3);
    cpu_write(win_b(5), 8'hA5);
    model[3*PB + 5] = 8'hA5;
    cpu_write(reg_a(0), 8'd3);
    cpu_read(win_a(5), d);
    chk(d == 8'hA5, "R1", "alias through window A", int'(d), 165);
    cpu_read(win_a(0), d);
    chk(d == model[3*PB], "R1", "window A read page 3", int'(d), int'(model[3*PB]));

    // R3 R4 R6: two back-to-back frames with ready high
    pace_on = 1;
    push_frame(0); push_frame(0);
    wait_empty();
    pace_on = 0;

    // R5: random back-pressure
    bp_mode = 1;
    push_frame(0); push_frame(0); push_frame(0);
    wait_empty();
    bp_mode = 0;

    // R7: deferred visible page
    push_frame(0); push_frame(1);
    wait_sync();
    cpu_write(reg_a(2), 8'd1);
    cpu_read(reg_a(2), d);
    chk(d == 8'd0, "R7", "visible page before retrace", int'(d), 0);
    wait_empty();
    cpu_read(reg_a(2), d);
    chk(d == 8'd1, "R7", "visible page after retrace", int'(d), 1);

    // R8: scanline readback
    do @(negedge clk); while (!(px_valid && px_ready && px_frame_start));
    cpu_read(reg_a(3), d);
    chk(d == 8'd0, "R8", "scanline at row 0", int'(d), 0);
    n = 0;
    while (n < 2) begin
      @(negedge clk);
      if (px_valid && px_ready && px_row_start) n++;
    end
    cpu_read(reg_a(3), d);
    chk(d == 8'd2, "R8", "scanline at row 2", int'(d), 2);

    // R9: armed compare with irq enabled
    cpu_write(reg_a(4), 8'd1);
    irq_row = 2; irq_watch = 1;
    push_frame(1);
    wait_sync();
    cpu_write(reg_a(3), 8'd2);
    wait_empty();
    irq_watch = 0;
    repeat (5) @(negedge clk);
    chk(irq == 1'b1, "R10", "irq held until cleared", int'(irq), 1);
    cpu_read(reg_a(4), d);
    chk(d == 8'd3, "R10", "pending and enable", int'(d), 3);

    // R10 clear
    cpu_write(reg_a(4), 8'd3);
    @(negedge clk);
    chk(irq == 1'b0, "R10", "irq after clear", int'(irq), 0);

    // R9 one-shot: a full further frame without re-arming
    push_frame(1);
    wait_empty();
    push_frame(1);
    wait_empty();
    chk(irq == 1'b0, "R9", "no second irq without re-arm", int'(irq), 0);
    cpu_read(reg_a(4), d);
    chk(d == 8'd1, "R9", "pending stays clear", int'(d), 1);

    // R10 masked pending
    cpu_write(reg_a(4), 8'd0);
    push_frame(1);
    wait_sync();
    cpu_write(reg_a(3), 8'd1);
    wait_empty();
    chk(irq == 1'b0, "R10", "masked irq", int'(irq), 0);
    cpu_read(reg_a(4), d);
    chk(d == 8'd2, "R10", "pending while masked", int'(d), 2);
    cpu_write(reg_a(4), 8'd1);
    @(negedge clk);
    chk(irq == 1'b1, "R10", "irq on unmask", int'(irq), 1);
    cpu_write(reg_a(4), 8'd3);
    @(negedge clk);
    chk(irq == 1'b0, "R10", "irq cleared", int'(irq), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule